// File: doc/BRIEF.md
# Memory Module Bank Map Controller

This block holds the configuration registers of a controller for six memory-module sockets and turns them into a physical address map. Software reaches it through a byte-wide I/O port interface made of an address, a read strobe, a write strobe and write/read data. Which sockets are populated, and which of them carry a large module rather than a small one, arrive as static configuration inputs. Software reads this back through two read-only status ports. It then programs the end address of every bank through one shared size port.

Eight 5-bit end-address slots sit behind the size port. A write carries the slot number in its top three data bits and the end address in its low five bits. A read returns the slot named by a readback pointer and then moves the pointer on by one. Reading the presence port moves the pointer back to slot 0. Bank n takes its base from slot n and its end from slot n+1, in units of 8 MB, and bank 0 always starts at 0. A combinational decoder compares address bits 28:23 with every enabled window. It returns a one-hot bank select or a miss flag.

A small state machine controls start-up. At reset it enters `ST_PACK` when the auto-configure input is high, and `ST_READY` otherwise. In `ST_PACK` it spends one cycle per socket and writes cumulative end addresses, so that the populated sockets lie back to back from address 0. It then takes the transition `ST_PACK -> ST_READY` after the last socket. `ST_READY` loops on itself until the next reset.

Top module: `bank_map_ctrl`

## Requirements
- R1: A read of I/O address 0x803 returns bit n = 1 exactly when socket n is populated and large (32 MB). Bits 7:6 read 0.
- R2: A read of 0x804 returns bit n = 0 when socket n is populated and 1 when it is empty, with bits 7:6 = 1. The same read sets the readback pointer to 0.
- R3: A write to 0x820 stores data bits 4:0 into the slot selected by data bits 7:5.
- R4: A read of 0x820 returns {3'b000, slot[pointer]}. The pointer then advances by one and wraps from 7 to 0.
- R5: A read of 0x841 returns 0x01, meaning no parity error. A read of any unmapped address returns 0x00. Writes to any address other than 0x820 change no slot.
- R6: Read data appears on `io_rdata_o` on the clock edge that samples the read strobe. It holds its value until the next accepted read.
- R7: Bank n (0..5) has base slot[n], or 0 for n = 0, and end slot[n+1]. It is enabled only when socket n is populated and end differs from base. It hits when base <= addr[28:23] < end. Address bits 31:29 and 22:0 are ignored.
- R8: `bank_sel_o` is the one-hot select of the lowest-numbered hitting bank, so overlapping windows go to the lower socket. `bank_miss_o` is 1 exactly when no bank hits.
- R9: The values in slot 0 and slot 7 read back normally but have no effect on any bank window.
- R10: With auto-configure high at reset, the block spends N_SOCK cycles in `ST_PACK`. Slot n+1 receives the running sum of module sizes of sockets 0..n (large = 4, small = 1, empty = 0 units). Slots 0 and 7 stay 0, and I/O accesses during packing are ignored. With auto-configure low, every slot resets to 0 and the block goes straight to `ST_READY`.
- R11: During and after reset, `io_rdata_o` is 0x00 and the readback pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_cfg_i | input | 1 | Pack the map automatically when reset is released |
| sock_pop_i | input | 6 | Socket n holds a module |
| sock_big_i | input | 6 | Module in socket n is 32 MB (else 8 MB) |
| io_addr_i | input | 12 | I/O port address |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Registered I/O read data |
| mem_addr_i | input | 32 | Physical memory address to decode |
| bank_sel_o | output | 6 | One-hot bank select |
| bank_miss_o | output | 1 | No enabled bank window contains the address |

## Verification
The in-line assertions check the invariants that hold on every cycle. These are the one-hot and lowest-wins shape of the select and its exclusion with the miss flag, pointer advance and rewind on size and presence reads, slot capture on size writes, slot stability under other writes, read-data hold, and the exit from `ST_PACK`. The actual window arithmetic can only be shown by the bench's scenarios: which bank a given address reaches, the packed end addresses built from the socket mix, overlap resolution, and the fact that slots 0 and 7 never shape a window. The same holds for the readback order through a full wrap and for ignored writes made during packing.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    // I/O port addresses; software depends on these values
    localparam logic [11:0] IOA_ID   = 12'h803;
    localparam logic [11:0] IOA_PRES = 12'h804;
    localparam logic [11:0] IOA_SIZE = 12'h820;
    localparam logic [11:0] IOA_PAR  = 12'h841;

    localparam logic [7:0] PARITY_CLEAN = 8'h01;

    typedef enum logic {
        ST_PACK  = 1'b0,
        ST_READY = 1'b1
    } cfg_state_e;

endpackage

// File: rtl/bank_map_slots.sv
module bank_map_slots
    import bank_map_pkg::*;
#(
    parameter int N_SOCK      = 6,
    parameter int N_SLOT      = 8,
    parameter int UNIT_W      = 5,
    parameter int DATA_W      = 8,
    parameter int IOA_W       = 12,
    parameter int BIG_UNITS   = 4,
    parameter int SMALL_UNITS = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             auto_cfg_i,
    input  logic [N_SOCK-1:0]                pop_i,
    input  logic [N_SOCK-1:0]                big_i,
    input  logic [IOA_W-1:0]                 io_addr_i,
    input  logic                             io_rd_i,
    input  logic                             io_wr_i,
    input  logic [DATA_W-1:0]                io_wdata_i,
    output logic [DATA_W-1:0]                io_rdata_o,
    output logic [N_SLOT-1:0][UNIT_W-1:0]    slot_o
);

    localparam int IDX_W = $clog2(N_SLOT);
    localparam int CNT_W = $clog2(N_SOCK);

    cfg_state_e                   state_q, state_d;
    logic [CNT_W-1:0]             pack_cnt_q;
    logic [UNIT_W-1:0]            pack_acc_q;
    logic [IDX_W-1:0]             idx_q;
    logic [N_SLOT-1:0][UNIT_W-1:0] slot_q;
    logic [DATA_W-1:0]            rdata_q, rd_mux;

    logic              ready, pack_last;
    logic              rd_acc, rd_size, rd_pres, wr_size;
    logic [IDX_W-1:0]  wr_slot, pack_slot;
    logic [UNIT_W-1:0] wr_val, pack_unit, pack_sum;

    assign ready     = (state_q == ST_READY);
    assign pack_last = (pack_cnt_q == CNT_W'(N_SOCK - 1));
    assign rd_acc    = ready && io_rd_i;
    assign rd_size   = rd_acc && (io_addr_i == IOA_SIZE);
    assign rd_pres   = rd_acc && (io_addr_i == IOA_PRES);
    assign wr_size   = ready && io_wr_i && (io_addr_i == IOA_SIZE);
    assign wr_slot   = io_wdata_i[DATA_W-1 -: IDX_W];
    assign wr_val    = io_wdata_i[UNIT_W-1:0];

    assign pack_unit = !pop_i[pack_cnt_q] ? '0 :
                       big_i[pack_cnt_q]  ? UNIT_W'(BIG_UNITS) : UNIT_W'(SMALL_UNITS);
    assign pack_sum  = pack_acc_q + pack_unit;
    assign pack_slot = IDX_W'(pack_cnt_q) + IDX_W'(1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PACK:  state_d = pack_last ? ST_READY : ST_PACK;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= auto_cfg_i ? ST_PACK : ST_READY;
        else        state_q <= state_d;
    end

    // read data selection
    always_comb begin
        unique case (io_addr_i)
            IOA_ID:   rd_mux = DATA_W'(pop_i & big_i);
            IOA_PRES: rd_mux = ~DATA_W'(pop_i);
            IOA_SIZE: rd_mux = DATA_W'(slot_q[idx_q]);
            IOA_PAR:  rd_mux = PARITY_CLEAN;
            default:  rd_mux = '0;
        endcase
    end

    // slots, pointer, packing walk and read data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q     <= '0;
            idx_q      <= '0;
            pack_cnt_q <= '0;
            pack_acc_q <= '0;
            rdata_q    <= '0;
        end else begin
            if (state_q == ST_PACK) begin
                slot_q[pack_slot] <= pack_sum;
                pack_acc_q        <= pack_sum;
                pack_cnt_q        <= pack_cnt_q + 1'b1;
            end
            if (wr_size) slot_q[wr_slot] <= wr_val;
            if (rd_size) idx_q <= idx_q + 1'b1;
            if (rd_pres) idx_q <= '0;
            if (rd_acc)  rdata_q <= rd_mux;
        end
    end

    assign io_rdata_o = rdata_q;
    assign slot_o     = slot_q;

    // R4: pointer advances modulo slot count on each size read
    a_r4_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
        rd_size |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

    // R2: presence read rewinds the pointer
    a_r2_idx_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pres |=> idx_q == '0);

    // R3: size write lands in the tagged slot
    a_r3_slot_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_size |=> slot_q[$past(wr_slot)] == $past(wr_val));

    // R5: writes elsewhere leave all slots alone
    a_r5_other_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && io_wr_i && io_addr_i != IOA_SIZE) |=> $stable(slot_q));

    // R6: read data holds without an accepted read
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(io_rdata_o));

    // R10: packing ends after the last socket, ready is terminal
    a_r10_pack_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PACK && pack_last) |=> state_q == ST_READY);
    a_r10_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |=> state_q == ST_READY);

endmodule

// File: rtl/bank_map_decode.sv
module bank_map_decode #(
    parameter int N_SOCK   = 6,
    parameter int N_SLOT   = 8,
    parameter int UNIT_W   = 5,
    parameter int ADDR_W   = 32,
    parameter int UNIT_LSB = 23,
    parameter int UNIT_MSB = 28
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SLOT-1:0][UNIT_W-1:0] slot_i,
    input  logic [N_SOCK-1:0]             pop_i,
    input  logic [ADDR_W-1:0]             addr_i,
    output logic [N_SOCK-1:0]             bank_sel_o,
    output logic                          miss_o
);

    localparam int CMP_W = UNIT_MSB - UNIT_LSB + 1;

    logic [CMP_W-1:0]  unit;
    logic [N_SOCK-1:0] hit;

    assign unit = addr_i[UNIT_MSB:UNIT_LSB];

    for (genvar g = 0; g < N_SOCK; g++) begin : g_bank
        logic [UNIT_W-1:0] base, lim;
        if (g == 0) begin : g_first
            assign base = '0;
        end else begin : g_rest
            assign base = slot_i[g];
        end
        assign lim    = slot_i[g+1];
        assign hit[g] = pop_i[g] && (lim != base) &&
                        (CMP_W'(base) <= unit) && (unit < CMP_W'(lim));
    end

    // lowest set bit of the hit vector wins
    assign bank_sel_o = hit & (~hit + 1'b1);
    assign miss_o     = (hit == '0);

    logic unused_bits;
    assign unused_bits = ^{addr_i[ADDR_W-1:UNIT_MSB+1], addr_i[UNIT_LSB-1:0],
                           slot_i[0], slot_i[N_SLOT-1]};

    // R8: at most one bank selected
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel_o));

    // R8: miss and select exclude each other
    a_r8_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o == (bank_sel_o == '0));

    // R8: selected bank hits and no lower bank hits
    a_r8_sel_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel_o & ~hit) == '0);
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel_o != '0) |-> (((bank_sel_o - 1'b1) & hit) == '0));

    // R7: a window hit requires a populated socket
    a_r7_pop_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel_o & ~pop_i) == '0);

endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl #(
    parameter int N_SOCK = 6,
    parameter int N_SLOT = 8,
    parameter int UNIT_W = 5,
    parameter int DATA_W = 8,
    parameter int IOA_W  = 12,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_cfg_i,
    input  logic [N_SOCK-1:0] sock_pop_i,
    input  logic [N_SOCK-1:0] sock_big_i,
    input  logic [IOA_W-1:0]  io_addr_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    input  logic [DATA_W-1:0] io_wdata_i,
    output logic [DATA_W-1:0] io_rdata_o,
    input  logic [ADDR_W-1:0] mem_addr_i,
    output logic [N_SOCK-1:0] bank_sel_o,
    output logic              bank_miss_o
);

    logic [N_SLOT-1:0][UNIT_W-1:0] slots;

    bank_map_slots #(
        .N_SOCK (N_SOCK),
        .N_SLOT (N_SLOT),
        .UNIT_W (UNIT_W),
        .DATA_W (DATA_W),
        .IOA_W  (IOA_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_cfg_i (auto_cfg_i),
        .pop_i      (sock_pop_i),
        .big_i      (sock_big_i),
        .io_addr_i  (io_addr_i),
        .io_rd_i    (io_rd_i),
        .io_wr_i    (io_wr_i),
        .io_wdata_i (io_wdata_i),
        .io_rdata_o (io_rdata_o),
        .slot_o     (slots)
    );

    bank_map_decode #(
        .N_SOCK (N_SOCK),
        .N_SLOT (N_SLOT),
        .UNIT_W (UNIT_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_i     (slots),
        .pop_i      (sock_pop_i),
        .addr_i     (mem_addr_i),
        .bank_sel_o (bank_sel_o),
        .miss_o     (bank_miss_o)
    );

endmodule

// File: tb/bank_map_ctrl_tb.sv
module bank_map_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_DEC      = 11;

    // {address, expected select, expected miss} for the auto-packed map
    localparam logic [38:0] DEC_TBL [0:N_DEC-1] = '{
        {32'h0000_0000, 6'b000001, 1'b0},
        {32'h007F_FFFF, 6'b000001, 1'b0},
        {32'h0180_0000, 6'b000001, 1'b0},
        {32'h0200_0000, 6'b000010, 1'b0},
        {32'h0380_0000, 6'b000010, 1'b0},
        {32'h0400_0000, 6'b000100, 1'b0},
        {32'h0480_0000, 6'b001000, 1'b0},
        {32'h0500_0000, 6'b100000, 1'b0},
        {32'h0580_0000, 6'b000000, 1'b1},
        {32'h1F80_0000, 6'b000000, 1'b1},
        {32'hE200_0000, 6'b000010, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auto_cfg = 1'b1;
    logic [5:0]  pop = 6'b101111;
    logic [5:0]  big = 6'b010011;
    logic [11:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [31:0] mem_addr = '0;
    logic [5:0]  bank_sel;
    logic        bank_miss;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_map_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_cfg_i  (auto_cfg),
        .sock_pop_i  (pop),
        .sock_big_i  (big),
        .io_addr_i   (io_addr),
        .io_rd_i     (io_rd),
        .io_wr_i     (io_wr),
        .io_wdata_i  (io_wdata),
        .io_rdata_o  (io_rdata),
        .mem_addr_i  (mem_addr),
        .bank_sel_o  (bank_sel),
        .bank_miss_o (bank_miss)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] d;
        io_read(a, d);
        chk(tag, 64'(d), 64'(exp));
    endtask

    task automatic dec_chk(input string tag, input logic [31:0] a,
                           input logic [5:0] sel, input logic miss);
        @(negedge clk);
        mem_addr = a;
        #1;
        chk(tag, 64'({bank_sel, bank_miss}), 64'({sel, miss}));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // auto-configured reset
        repeat (3) @(negedge clk);
        chk("R11 rdata in reset", 64'(io_rdata), 64'h0);
        // write to slot 7 in the first packing cycle must be ignored (R10)
        rst_n = 1'b1;
        io_addr = 12'h820; io_wdata = 8'hFF; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        repeat (10) @(negedge clk);

        // R7 R8 R10: decode through the packed map
        for (int i = 0; i < N_DEC; i++) begin
            dec_chk($sformatf("R7 R10 table entry %0d", i), DEC_TBL[i][38:7],
                    DEC_TBL[i][6:1], DEC_TBL[i][0]);
        end

        rd_chk("R1 id", 12'h803, 8'h03);
        rd_chk("R2 presence", 12'h804, 8'hD0);
        rd_chk("R10 slot0", 12'h820, 8'd0);
        rd_chk("R10 slot1", 12'h820, 8'd4);
        rd_chk("R10 slot2", 12'h820, 8'd8);
        rd_chk("R10 slot3", 12'h820, 8'd9);
        rd_chk("R10 slot4", 12'h820, 8'd10);
        rd_chk("R10 slot5", 12'h820, 8'd10);
        rd_chk("R10 slot6", 12'h820, 8'd11);
        rd_chk("R10 slot7 untouched by pack-time write", 12'h820, 8'd0);

        // manual-configuration reset
        @(negedge clk);
        rst_n = 1'b0; auto_cfg = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 rdata after reset", 64'(io_rdata), 64'h0);
        rst_n = 1'b1;
        dec_chk("R10 all slots zero gives miss", 32'h0000_0000, 6'b000000, 1'b1);
        rd_chk("R11 pointer at slot0", 12'h820, 8'd0);

        io_write(12'h820, 8'h23);   // slot1 = 3
        io_write(12'h820, 8'h43);   // slot2 = 3
        io_write(12'h820, 8'h66);   // slot3 = 6
        io_write(12'h820, 8'h02);   // slot0 = 2
        io_write(12'h820, 8'hFF);   // slot7 = 31
        io_write(12'h820, 8'h85);   // slot4 = 5
        io_write(12'h820, 8'h41);   // slot2 = 1
        io_write(12'h820, 8'hA8);   // slot5 = 8

        dec_chk("R9 slot0 does not move bank0 base", 32'h0080_0000, 6'b000001, 1'b0);
        dec_chk("R8 overlap lowest socket wins", 32'h0100_0000, 6'b000001, 1'b0);
        dec_chk("R3 bank2 window from slot2/slot3", 32'h0200_0000, 6'b000100, 1'b0);
        dec_chk("R7 bank2 last unit", 32'h0280_0000, 6'b000100, 1'b0);
        dec_chk("R7 end at or below base disables", 32'h0300_0000, 6'b000000, 1'b1);
        dec_chk("R7 empty socket never hits", 32'h0380_0000, 6'b000000, 1'b1);
        dec_chk("R9 slot7 makes no window", 32'h0A00_0000, 6'b000000, 1'b1);

        // writes to read-only or unmapped ports change nothing
        io_write(12'h821, 8'h25);
        io_write(12'h804, 8'h00);
        io_write(12'h803, 8'hFF);
        dec_chk("R5 write to other port leaves slot1", 32'h0200_0000, 6'b000100, 1'b0);
        rd_chk("R5 id unchanged", 12'h803, 8'h03);
        rd_chk("R5 parity clean", 12'h841, 8'h01);
        rd_chk("R5 unmapped reads zero", 12'h800, 8'h00);

        // full readback with wrap
        rd_chk("R2 presence rewinds", 12'h804, 8'hD0);
        rd_chk("R4 slot0", 12'h820, 8'd2);
        rd_chk("R4 slot1", 12'h820, 8'd3);
        rd_chk("R4 slot2", 12'h820, 8'd1);
        rd_chk("R4 slot3", 12'h820, 8'd6);
        rd_chk("R4 slot4", 12'h820, 8'd5);
        rd_chk("R4 slot5", 12'h820, 8'd8);
        rd_chk("R4 slot6", 12'h820, 8'd0);
        rd_chk("R4 slot7", 12'h820, 8'd31);
        rd_chk("R4 wrap to slot0", 12'h820, 8'd2);
        rd_chk("R4 slot1 after wrap", 12'h820, 8'd3);
        rd_chk("R2 presence mid-walk", 12'h804, 8'hD0);
        rd_chk("R2 pointer back at slot0", 12'h820, 8'd2);

        // read data holds while idle
        @(negedge clk);
        io_addr = 12'h841;
        repeat (3) @(negedge clk);
        chk("R6 rdata holds without read", 64'(io_rdata), 64'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule